// File: doc/BRIEF.md
# Vertical Frame Timing Generator for a Raster Panel

This block sequences the rows of a display frame. A separate horizontal timer issues a one-cycle end-of-line strobe at the close of each line. The block counts those strobes and moves each frame through four phases in a fixed order: vertical sync, back porch, active lines and front porch. In every phase the length is a whole number of lines. The outputs are a vertical sync level, an enable that marks the lines whose pixels are sent, and one-cycle strobes at the start and at the end of each frame.

There are two sync styles. In pulsed mode the sync phase drives the vertical sync output high. In line-insertion mode the sync phase still takes up its lines, but the sync output stays low. In both styles the back porch count starts only once the sync phase is over. The configuration fields are captured at each frame boundary, so software can rewrite them at any time without breaking the frame in progress.

Top module: `lcd_vframe_timer`

## Requirements
- R1: While reset is asserted, and while `enable` is low, `vSync`, `lineActive`, `frameStart` and `frameEnd` are all 0.
- R2: After `enable` rises, the first `lineEnd` strobe starts a frame, and the sync phase is the current line from the next cycle on.
- R3: With `cfgPulsedSync` = 1 captured, `vSync` is 1 for exactly `cfgSyncWidth`+1 lines at the start of each frame, and 0 during every other line.
- R4: With `cfgPulsedSync` = 0 captured, the sync phase still lasts `cfgSyncWidth`+1 lines, but `vSync` stays 0 for the whole frame.
- R5: After the sync phase, `cfgBackPorch` (0 to 255) lines pass with `lineActive` = 0 before the first active line.
- R6: `lineActive` is 1 for exactly `cfgLines` consecutive lines per frame. A `cfgLines` of 0 is taken as 1.
- R7: After the last active line, `cfgFrontPorch` (0 to 255) lines pass with `lineActive` = 0. `lineEnd` strobes are still counted during these lines.
- R8: A porch value of 0 skips that phase, and the following phase begins on the same `lineEnd` strobe.
- R9: `frameStart` is a one-cycle pulse in the cycle right after the `lineEnd` that begins the first active line.
- R10: `frameEnd` is a one-cycle pulse in the cycle right after the `lineEnd` that ends the front porch, or the last active line when the front porch is 0. The next frame's sync phase begins on that same strobe.
- R11: All configuration inputs are captured on the `lineEnd` that starts a frame. Changes made later in the frame take effect from the next frame on.
- R12: When `enable` falls, the block returns to the idle state of R1 in the next cycle, whatever phase it was in.
- R13: Outputs change only in the cycle after a `lineEnd` strobe, or after a change of `enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the frame sequence; low forces the idle state |
| lineEnd | input | 1 | One-cycle strobe at the end of each horizontal line |
| cfgSyncWidth | input | 6 | Sync phase length minus one, in lines |
| cfgBackPorch | input | 8 | Back porch length in lines |
| cfgFrontPorch | input | 8 | Front porch length in lines |
| cfgLines | input | 10 | Active lines per frame |
| cfgPulsedSync | input | 1 | 1: pulsed vertical sync, 0: line-insertion style |
| vSync | output | 1 | Vertical sync level, active high |
| lineActive | output | 1 | High during lines whose pixels are output |
| frameStart | output | 1 | Pulse as the first active line begins |
| frameEnd | output | 1 | Pulse as the front porch completes |

## Verification
Some properties are checked by assertions on every cycle. The phase holds still between strobes. A low `enable` always leads to idle. The captured configuration changes only at a frame boundary. The line counter never passes the limit of its phase. Each frame strobe agrees with the phase it marks. Whether the line counts come out right can only be shown by the bench's scenarios: sync width, porch lengths, the count of active lines, zero-porch skipping, the two sync styles and the deferred effect of mid-frame writes. For this, the bench compares every output against a line-by-line queue model. It does so under spaced and back-to-back strobes, at the maximum field values and across a disable in the middle of a frame.

// File: rtl/lcd_vframe_pkg.sv
package lcd_vframe_pkg;

  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } phase_t;

  // Commands from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic clearCnt;
    logic incCnt;
  } ctrlStrobe_t;

  // Conditions reported by the datapath
  typedef struct packed {
    logic atLimit;
    logic backZero;
    logic frontZero;
  } dpStatus_t;

endpackage

// File: rtl/lcd_vframe_dp.sv
module lcd_vframe_dp
  import lcd_vframe_pkg::*;
#(
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8,
  parameter int LINE_W  = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  phase_t              phase,
  input  logic [SYNC_W-1:0]   cfgSyncWidth,
  input  logic [PORCH_W-1:0]  cfgBackPorch,
  input  logic [PORCH_W-1:0]  cfgFrontPorch,
  input  logic [LINE_W-1:0]   cfgLines,
  input  logic                cfgPulsedSync,
  output dpStatus_t           status,
  output logic                modeActive
);

  localparam int WIDE_A = (LINE_W > PORCH_W) ? LINE_W : PORCH_W;
  localparam int CNT_W  = (WIDE_A > SYNC_W) ? WIDE_A : SYNC_W;

  logic [SYNC_W-1:0]  syncWQ;
  logic [PORCH_W-1:0] backQ;
  logic [PORCH_W-1:0] frontQ;
  logic [LINE_W-1:0]  linesQ;
  logic               modeQ;
  logic [CNT_W-1:0]   lineCnt;
  logic [CNT_W-1:0]   limit;

  // Frame configuration, captured only at a frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncWQ <= '0;
      backQ  <= '0;
      frontQ <= '0;
      linesQ <= LINE_W'(1);
      modeQ  <= 1'b0;
    end else if (strobe.latchCfg) begin
      syncWQ <= cfgSyncWidth;
      backQ  <= cfgBackPorch;
      frontQ <= cfgFrontPorch;
      linesQ <= (cfgLines == '0) ? LINE_W'(1) : cfgLines;
      modeQ  <= cfgPulsedSync;
    end
  end

  // Line counter shared by all phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lineCnt <= '0;
    else if (strobe.clearCnt) lineCnt <= '0;
    else if (strobe.incCnt)   lineCnt <= lineCnt + CNT_W'(1);
  end

  // Last count value of the current phase
  always_comb begin
    case (phase)
      PH_SYNC:   limit = CNT_W'(syncWQ);
      PH_BACK:   limit = CNT_W'(backQ) - CNT_W'(1);
      PH_ACTIVE: limit = CNT_W'(linesQ) - CNT_W'(1);
      default:   limit = CNT_W'(frontQ) - CNT_W'(1);
    endcase
  end

  assign status.atLimit   = (lineCnt == limit);
  assign status.backZero  = (backQ == '0);
  assign status.frontZero = (frontQ == '0);
  assign modeActive       = modeQ;

  // R11: captured fields hold between frame boundaries
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchCfg |=> $stable({syncWQ, backQ, frontQ, linesQ, modeQ}));

  // R5 R6 R7: counter stays within the current phase's length
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt <= limit);

endmodule

// File: rtl/lcd_vframe_ctrl.sv
module lcd_vframe_ctrl
  import lcd_vframe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        lineEnd,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output phase_t      phase,
  output logic        running,
  output logic        frameStart,
  output logic        frameEnd
);

  phase_t nextPhase;
  logic   nextRun;
  logic   startNext;
  logic   endNext;

  always_comb begin
    strobe    = '0;
    nextPhase = phase;
    nextRun   = running;
    startNext = 1'b0;
    endNext   = 1'b0;
    if (!enable) begin
      nextPhase       = PH_SYNC;
      nextRun         = 1'b0;
      strobe.clearCnt = 1'b1;
    end else if (lineEnd) begin
      if (!running) begin
        nextRun         = 1'b1;
        strobe.latchCfg = 1'b1;
        strobe.clearCnt = 1'b1;
      end else if (!status.atLimit) begin
        strobe.incCnt = 1'b1;
      end else begin
        strobe.clearCnt = 1'b1;
        case (phase)
          PH_SYNC: begin
            if (status.backZero) begin
              nextPhase = PH_ACTIVE;
              startNext = 1'b1;
            end else begin
              nextPhase = PH_BACK;
            end
          end
          PH_BACK: begin
            nextPhase = PH_ACTIVE;
            startNext = 1'b1;
          end
          PH_ACTIVE: begin
            if (status.frontZero) begin
              nextPhase       = PH_SYNC;
              endNext         = 1'b1;
              strobe.latchCfg = 1'b1;
            end else begin
              nextPhase = PH_FRONT;
            end
          end
          default: begin
            nextPhase       = PH_SYNC;
            endNext         = 1'b1;
            strobe.latchCfg = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_SYNC;
      running    <= 1'b0;
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
    end else begin
      phase      <= nextPhase;
      running    <= nextRun;
      frameStart <= startNext;
      frameEnd   <= endNext;
    end
  end

  // R13: nothing moves between line strobes
  a_r13_hold_between_lines: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !lineEnd) |=> ($stable(phase) && $stable(running)));

  // R12: disable forces idle one cycle later
  a_r12_disable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (phase == PH_SYNC && !running && !frameStart && !frameEnd));

  // R9: start strobe coincides with the first active line
  a_r9_start_in_active: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (phase == PH_ACTIVE && running));

  // R10: end strobe coincides with the new frame's sync phase
  a_r10_end_in_sync: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (phase == PH_SYNC && running));

  // R9 R10: the two strobes never overlap
  a_r10_strobes_apart: assert property (@(posedge clk) disable iff (!rstN)
    $countones({frameStart, frameEnd}) <= 1);

endmodule

// File: rtl/lcd_vframe_timer.sv
module lcd_vframe_timer
  import lcd_vframe_pkg::*;
#(
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8,
  parameter int LINE_W  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               lineEnd,
  input  logic [SYNC_W-1:0]  cfgSyncWidth,
  input  logic [PORCH_W-1:0] cfgBackPorch,
  input  logic [PORCH_W-1:0] cfgFrontPorch,
  input  logic [LINE_W-1:0]  cfgLines,
  input  logic               cfgPulsedSync,
  output logic               vSync,
  output logic               lineActive,
  output logic               frameStart,
  output logic               frameEnd
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  phase_t      phase;
  logic        running;
  logic        modeActive;

  lcd_vframe_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .lineEnd    (lineEnd),
    .status     (status),
    .strobe     (strobe),
    .phase      (phase),
    .running    (running),
    .frameStart (frameStart),
    .frameEnd   (frameEnd)
  );

  lcd_vframe_dp #(
    .SYNC_W  (SYNC_W),
    .PORCH_W (PORCH_W),
    .LINE_W  (LINE_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .phase         (phase),
    .cfgSyncWidth  (cfgSyncWidth),
    .cfgBackPorch  (cfgBackPorch),
    .cfgFrontPorch (cfgFrontPorch),
    .cfgLines      (cfgLines),
    .cfgPulsedSync (cfgPulsedSync),
    .status        (status),
    .modeActive    (modeActive)
  );

  assign vSync      = running && (phase == PH_SYNC) && modeActive;
  assign lineActive = (phase == PH_ACTIVE);

  // R1: idle means sitting in the sync phase
  a_r1_idle_in_sync: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (phase == PH_SYNC));

endmodule

// File: tb/lcd_vframe_timer_test.sv
module lcd_vframe_timer_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       lineEnd = 1'b0;
  logic [5:0] cfgSyncWidth = '0;
  logic [7:0] cfgBackPorch = '0;
  logic [7:0] cfgFrontPorch = '0;
  logic [9:0] cfgLines = '0;
  logic       cfgPulsedSync = 1'b0;
  logic       vSync, lineActive, frameStart, frameEnd;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_vframe_timer uut (
    .clk(clk), .rstN(rstN), .enable(enable), .lineEnd(lineEnd),
    .cfgSyncWidth(cfgSyncWidth), .cfgBackPorch(cfgBackPorch),
    .cfgFrontPorch(cfgFrontPorch), .cfgLines(cfgLines),
    .cfgPulsedSync(cfgPulsedSync),
    .vSync(vSync), .lineActive(lineActive),
    .frameStart(frameStart), .frameEnd(frameEnd)
  );

  // Reference: a queue of line labels for the rest of the frame
  byte lineQ[$];
  byte cur = "S";
  bit  mRun = 0;
  bit  mPulsed = 0;
  bit  eStart = 0;
  bit  eEnd = 0;
  bit  sawLine = 0;

  task automatic buildFrame();
    int n;
    lineQ.delete();
    for (int i = 0; i <= int'(cfgSyncWidth); i++) lineQ.push_back("S");
    for (int i = 0; i < int'(cfgBackPorch); i++) lineQ.push_back("B");
    n = (cfgLines == 0) ? 1 : int'(cfgLines);
    for (int i = 0; i < n; i++) lineQ.push_back("A");
    for (int i = 0; i < int'(cfgFrontPorch); i++) lineQ.push_back("F");
    mPulsed = cfgPulsedSync;
    cur = lineQ.pop_front();
  endtask

  always @(posedge clk) begin
    byte nxt;
    eStart = 0;
    eEnd = 0;
    sawLine = lineEnd;
    if (!rstN || !enable) begin
      mRun = 0;
      cur = "S";
      lineQ.delete();
    end else if (lineEnd) begin
      if (!mRun) begin
        mRun = 1;
        buildFrame();
      end else if (lineQ.size() == 0) begin
        eEnd = 1;
        buildFrame();
      end else begin
        nxt = lineQ.pop_front();
        if (nxt == "A" && cur != "A") eStart = 1;
        cur = nxt;
      end
    end
  end

  task automatic check1(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string idleTag;
    if (!finished) begin
      idleTag = mRun ? " R13" : " R1 R2 R12";
      check1({"R3 R4 R11", idleTag}, "vSync", vSync, mRun && cur == "S" && mPulsed);
      check1({"R5 R6 R7 R8", idleTag}, "lineActive", lineActive, mRun && cur == "A");
      check1({"R9", idleTag}, "frameStart", frameStart, eStart);
      check1({"R10", idleTag}, "frameEnd", frameEnd, eEnd);
    end
  end

  task automatic pulseLines(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lineEnd = 1'b1;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        lineEnd = 1'b0;
      end
    end
    @(negedge clk);
    lineEnd = 1'b0;
  endtask

  task automatic setCfg(int sw, int bp, int fp, int ln, bit pulsed);
    cfgSyncWidth  = 6'(sw);
    cfgBackPorch  = 8'(bp);
    cfgFrontPorch = 8'(fp);
    cfgLines      = 10'(ln);
    cfgPulsedSync = pulsed;
  endtask

  task automatic finish();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    // R1: reset, then strobes with enable low
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    setCfg(1, 2, 1, 4, 1);
    pulseLines(4, 1);
    // R2 R3 R5 R6 R7 R9 R10: pulsed mode, spaced strobes
    @(negedge clk);
    enable = 1'b1;
    pulseLines(5, 2);
    // R11: rewrite mid-frame
    setCfg(2, 3, 2, 2, 1);
    pulseLines(30, 2);
    // R8 R6: zero porches, zero lines, back-to-back strobes
    setCfg(0, 0, 0, 0, 1);
    pulseLines(14, 0);
    // R4: line-insertion style
    setCfg(2, 1, 2, 3, 0);
    pulseLines(30, 1);
    // R12: disable mid-frame, then resume
    setCfg(1, 2, 3, 5, 1);
    pulseLines(7, 1);
    @(negedge clk);
    enable = 1'b0;
    pulseLines(3, 1);
    @(negedge clk);
    enable = 1'b1;
    pulseLines(25, 1);
    // Field maxima
    setCfg(63, 255, 255, 1023, 1);
    pulseLines(3300, 0);
    repeat (3) @(negedge clk);
    finish();
  end

endmodule